// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block sits beside a processor with a 24-bit byte address bus. It turns each bus access into at most one of four active-low select lines, one per external memory or peripheral region. Each line has two 16-bit registers. The placement register sets the region start, the expected function code, the expected direction and an enable. The shape register sets the region size as an address mask, chooses which qualifiers are compared, and sets the number of wait states. Software loads these registers through a one-cycle write port.

Once a line is selected, the block produces the data acknowledge for the access on its own. The acknowledge comes after the programmed number of wait states, counted from the first clock edge at which the address strobe is seen low. A wait code of 7 hands the acknowledge to external logic. The locked write half of a test-and-set access has its own wait rule.

The wait sequencer has four states. `IDLE` waits for the strobe. `COUNT` counts down the waits. `ACK` drives the acknowledge. `HOLD` covers a strobe with no selected line or with external acknowledge.

The transitions are:
- `IDLE -> ACK` when the wait count is 0.
- `IDLE -> COUNT` when the wait count is 1 to 6.
- `IDLE -> HOLD` when no line is selected or the wait code is 7.
- `COUNT -> ACK` when the last wait is used up.
- From any state back to `IDLE` when the strobe rises.

Top module: `cs_decoder`

## Requirements
- R1: After reset, line 0 is enabled and selects byte addresses 0x000000 to 0x001FFF for any function code and either direction, with 6 wait states. Lines 1 to 3 are disabled.
- R2: A write with `reg_we`=1 stores `reg_wdata` into the register chosen by `reg_sel`. `reg_sel[2:1]` is the line number. `reg_sel[0]`=0 chooses the placement register and 1 chooses the shape register. Placement register layout: [15:13] function code, [12:2] region start A23..A13, [1] direction (1 = read, 0 = write), [0] enable. Shape register layout: [15:13] wait count, [12:2] compare mask for A23..A13 (1 = compare this bit), [1] compare direction, [0] compare function code.
- R3: A line matches when every address bit A23..A13 that its mask selects equals the programmed start. This gives power-of-two region sizes from 8 KB (all 11 bits compared) up to 16 MB (no bits compared).
- R4: When its function-code compare bit is set, a line matches only if `fc` equals the programmed code. When the bit is clear, any code other than 7 matches.
- R5: When its direction compare bit is set, a line matches only accesses whose `rw` equals the programmed direction. This gives read-only or write-only regions. When the bit is clear, both directions match.
- R6: No line asserts when `fc` is 3'b111 (interrupt acknowledge).
- R7: No line asserts for addresses 0xFFF000 to 0xFFFFFF, the internal register window.
- R8: When several enabled lines match, only the lowest-numbered one is driven low.
- R9: All four `cs_n` outputs stay high while `as_n` is high.
- R10: For a selected line with wait count w from 0 to 6, `dtack_n` goes low after the w-th clock edge that follows the first edge at which `as_n` is sampled low. It stays low until `as_n` rises, and the count starts again on each new strobe.
- R11: With wait code 7, or with no line selected, `dtack_n` stays high for the whole strobe.
- R12: On the write half of a locked access (`locked_rmw`=1 and `rw`=0), the wait count is forced to 0 unless `rmw_wait_en`=1. Locked reads always use the programmed count.
- R13: A line whose enable bit is clear never asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: line number and register kind |
| reg_wdata | input | 16 | Register write data |
| as_n | input | 1 | Address strobe, active low |
| addr | input | 24 | Byte address |
| fc | input | 3 | Function code of the access |
| rw | input | 1 | Direction: 1 = read, 0 = write |
| locked_rmw | input | 1 | Access belongs to a locked read-modify-write |
| rmw_wait_en | input | 1 | Allow wait states on the locked write half |
| cs_n | output | 4 | Chip-select lines, active low |
| dtack_n | output | 1 | Internal data acknowledge, active low |

## Verification
The bench programs four overlapping regions:
- an 8 KB region that passes every access,
- a 64 KB read-only region,
- an 8 KB write-only region tied to one function code,
- a 16 MB region that catches everything else.

It then sweeps every A23..A13 value, crossed with both directions and five function codes. This sweep separates the effects of the mask, the direction filter, the function-code filter, priority, the interrupt-acknowledge block and the register-window exclusion. Separate directed strobes measure the acknowledge delay for waits of 0, 2 and 6 and for external acknowledge. Further strobes compare locked reads against locked writes with the control bit both off and on.

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int NUM_LINES = 4;
    localparam int ADDR_W    = 24;
    localparam int BLK_LSB   = 13;
    localparam int CMP_W     = ADDR_W - BLK_LSB;
    localparam int SEL_W     = $clog2(NUM_LINES);
    localparam int WAIT_W    = 3;
    localparam logic [WAIT_W-1:0] WAIT_EXT = 3'd7;
    localparam logic [2:0] FC_IACK = 3'b111;

    typedef struct packed {
        logic [2:0]       fc;
        logic [CMP_W-1:0] start;
        logic             dir;
        logic             en;
    } place_t;

    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic [CMP_W-1:0]  mask;
        logic              dir_cmp;
        logic              fc_cmp;
    } shape_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_ACK   = 2'd2,
        ST_HOLD  = 2'd3
    } wstate_t;
endpackage

// File: rtl/cs_regbank.sv
module cs_regbank
    import cs_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [SEL_W:0]             reg_sel,
    input  logic [15:0]                reg_wdata,
    output place_t [NUM_LINES-1:0]     place_q,
    output shape_t [NUM_LINES-1:0]     shape_q
);
    localparam place_t BOOT_PLACE = '{fc: 3'd0, start: '0, dir: 1'b0, en: 1'b1};
    localparam shape_t BOOT_SHAPE = '{waits: 3'd6, mask: '1, dir_cmp: 1'b0, fc_cmp: 1'b0};

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic hit_line;
        assign hit_line = reg_we && (reg_sel[SEL_W:1] == SEL_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                place_q[i] <= (i == 0) ? BOOT_PLACE : '0;
                shape_q[i] <= (i == 0) ? BOOT_SHAPE : '0;
            end else if (hit_line) begin
                if (reg_sel[0]) shape_q[i] <= shape_t'(reg_wdata);
                else            place_q[i] <= place_t'(reg_wdata);
            end
        end
    end
endmodule

// File: rtl/cs_match.sv
module cs_match
    import cs_pkg::*;
(
    input  logic             en,
    input  logic [CMP_W-1:0] start,
    input  logic [CMP_W-1:0] mask,
    input  logic [2:0]       fc_prog,
    input  logic             fc_cmp,
    input  logic             dir_prog,
    input  logic             dir_cmp,
    input  logic [CMP_W-1:0] addr_hi,
    input  logic [2:0]       fc,
    input  logic             rw,
    output logic             hit
);
    logic addr_ok, fc_ok, dir_ok;

    always_comb begin
        addr_ok = ((addr_hi ^ start) & mask) == '0;
        fc_ok   = !fc_cmp || (fc == fc_prog);
        dir_ok  = !dir_cmp || (rw == dir_prog);
        hit     = en && addr_ok && fc_ok && dir_ok;
    end
endmodule

// File: rtl/cs_wait_fsm.sv
module cs_wait_fsm
    import cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              sel_valid,
    input  logic [WAIT_W-1:0] waits,
    output logic              dtack_n
);
    wstate_t           state_q, state_d;
    logic [WAIT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!as_n) begin
                    if (!sel_valid || waits == WAIT_EXT) state_d = ST_HOLD;
                    else if (waits == '0)                state_d = ST_ACK;
                    else begin
                        state_d = ST_COUNT;
                        cnt_d   = waits;
                    end
                end
            end
            ST_COUNT: begin
                if (as_n)              state_d = ST_IDLE;
                else if (cnt_q == 3'd1) state_d = ST_ACK;
                else                   cnt_d = cnt_q - 3'd1;
            end
            ST_ACK:  if (as_n) state_d = ST_IDLE;
            ST_HOLD: if (as_n) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        dtack_n = (state_q != ST_ACK);
    end

    a_r10_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_COUNT |-> cnt_q != '0);
    a_r10_ack_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_ACK) |-> $past(!as_n));
    a_r11_hold_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !as_n) |=> dtack_n);
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
    import cs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REGWIN_BASE = 24'hFFF000,
    parameter int                REGWIN_LSB  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_sel,
    input  logic [15:0]          reg_wdata,
    input  logic                 as_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [2:0]           fc,
    input  logic                 rw,
    input  logic                 locked_rmw,
    input  logic                 rmw_wait_en,
    output logic [NUM_LINES-1:0] cs_n,
    output logic                 dtack_n
);
    localparam int WIN_W = ADDR_W - REGWIN_LSB;

    place_t [NUM_LINES-1:0] place_q;
    shape_t [NUM_LINES-1:0] shape_q;
    logic   [NUM_LINES-1:0] hit, grant;
    logic   [SEL_W-1:0]     win_idx;
    logic                   any_hit, in_regwin, qualify, lock_wr;
    logic   [WAIT_W-1:0]    line_waits, eff_waits;
    logic   [REGWIN_LSB-1:0] unused_low;

    assign unused_low = addr[REGWIN_LSB-1:0];

    cs_regbank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .place_q   (place_q),
        .shape_q   (shape_q)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_cmp
        cs_match u_match (
            .en       (place_q[i].en),
            .start    (place_q[i].start),
            .mask     (shape_q[i].mask),
            .fc_prog  (place_q[i].fc),
            .fc_cmp   (shape_q[i].fc_cmp),
            .dir_prog (place_q[i].dir),
            .dir_cmp  (shape_q[i].dir_cmp),
            .addr_hi  (addr[ADDR_W-1:BLK_LSB]),
            .fc       (fc),
            .rw       (rw),
            .hit      (hit[i])
        );
    end

    always_comb begin
        in_regwin = addr[ADDR_W-1:REGWIN_LSB] == REGWIN_BASE[ADDR_W-1:REGWIN_LSB];
        qualify   = !as_n && (fc != FC_IACK) && !in_regwin;
        grant     = '0;
        win_idx   = '0;
        any_hit   = 1'b0;
        for (int k = NUM_LINES - 1; k >= 0; k--) begin
            if (hit[k]) begin
                win_idx = SEL_W'(k);
                any_hit = 1'b1;
            end
        end
        if (qualify && any_hit) grant[win_idx] = 1'b1;
        cs_n       = ~grant;
        line_waits = shape_q[win_idx].waits;
        lock_wr    = locked_rmw && !rw;
        eff_waits  = (lock_wr && !rmw_wait_en && line_waits != WAIT_EXT) ? '0 : line_waits;
    end

    cs_wait_fsm u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (as_n),
        .sel_valid (qualify && any_hit),
        .waits     (eff_waits),
        .dtack_n   (dtack_n)
    );

    a_r8_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    a_r9_strobe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (&cs_n));
    a_r6_no_iack: assert property (@(posedge clk) disable iff (!rst_n)
        (fc == FC_IACK) |-> (&cs_n));
    a_r7_regwin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1:REGWIN_LSB] == {WIN_W{1'b1}}) |-> (&cs_n));
    a_r10_ack_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> $past(!as_n));
endmodule

// File: tb/cs_decoder_test.sv
module cs_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        as_n = 1'b1;
    logic [23:0] addr = '0;
    logic [2:0]  fc = 3'd1;
    logic        rw = 1'b1;
    logic        locked_rmw = 1'b0;
    logic        rmw_wait_en = 1'b0;
    logic [3:0]  cs_n;
    logic        dtack_n;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    cs_decoder uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .as_n(as_n), .addr(addr), .fc(fc), .rw(rw),
        .locked_rmw(locked_rmw), .rmw_wait_en(rmw_wait_en),
        .cs_n(cs_n), .dtack_n(dtack_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h fc=%0d rw=%0b actual=%h expected=%h",
                     tag, addr, fc, rw, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        reg_sel = sel; reg_wdata = data; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // bench model: region table in plain address ranges
    bit line2_on = 1'b1;
    function automatic logic [3:0] model(input logic [23:0] a, input logic [2:0] f, input logic r);
        int sel;
        if (f == 3'd7 || a >= 24'hFFF000) return 4'hF;
        if (a < 24'h002000)                                       sel = 0;
        else if (a >= 24'h100000 && a < 24'h110000 && r)          sel = 1;
        else if (line2_on && a >= 24'h200000 && a < 24'h202000 && !r && f == 3'd5) sel = 2;
        else                                                      sel = 3;
        return ~(4'b1 << sel);
    endfunction

    // returns edges until acknowledge, 0 if none within 12
    task automatic strobe(input logic [23:0] a, input logic [2:0] f, input logic r,
                          input logic lk, output int n);
        @(negedge clk);
        addr = a; fc = f; rw = r; locked_rmw = lk; as_n = 1'b0;
        n = 0;
        for (int i = 1; i <= 12; i++) begin
            @(posedge clk); @(negedge clk);
            if (!dtack_n) begin n = i; break; end
        end
        as_n = 1'b1; locked_rmw = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle", {28'h0, cs_n}, 32'hF);
        check("R10 idle dtack", {31'h0, dtack_n}, 32'h1);

        // R1: boot defaults
        as_n = 1'b0;
        for (int f = 0; f < 8; f++) begin
            for (int r = 0; r < 2; r++) begin
                fc = 3'(f); rw = 1'(r);
                addr = 24'h000000; #1;
                check("R1 boot low", {28'h0, cs_n}, (f == 7) ? 32'hF : 32'hE);
                addr = 24'h001FFE; #1;
                check("R1 boot top", {28'h0, cs_n}, (f == 7) ? 32'hF : 32'hE);
                addr = 24'h002000; #1;
                check("R1 outside", {28'h0, cs_n}, 32'hF);
                addr = 24'h800000; #1;
                check("R13 lines off", {28'h0, cs_n}, 32'hF);
            end
        end
        as_n = 1'b1;
        @(negedge clk);
        strobe(24'h000010, 3'd6, 1'b1, 1'b0, n);
        check("R1 boot waits", n, 7);
        strobe(24'h004000, 3'd6, 1'b1, 1'b0, n);
        check("R11 unselected", n, 0);

        // R2: program regions
        wr(3'd2, 16'h0203); wr(3'd3, 16'h5FE2);
        wr(3'd4, 16'hA401); wr(3'd5, 16'h1FFF);
        wr(3'd6, 16'h0001); wr(3'd7, 16'hE000);

        // R3 R4 R5 R6 R7 R8 sweep
        as_n = 1'b0;
        for (int a = 0; a < 2048; a++) begin
            for (int r = 0; r < 2; r++) begin
                for (int k = 0; k < 5; k++) begin
                    logic [2:0] fv;
                    fv = (k == 0) ? 3'd1 : (k == 1) ? 3'd2 : (k == 2) ? 3'd5 : (k == 3) ? 3'd6 : 3'd7;
                    addr = {11'(a), (a[0] ? 13'h1000 : 13'h0000)};
                    fc = fv; rw = 1'(r); #1;
                    check("R3/R4/R5/R6/R7/R8 sweep", {28'h0, cs_n}, {28'h0, model(addr, fv, 1'(r))});
                end
            end
        end
        addr = 24'h000100; fc = 3'd5; rw = 1'b1; #1;
        check("R8 overlap to line0", {28'h0, cs_n}, 32'hE);
        addr = 24'hFFF800; #1;
        check("R7 regwin", {28'h0, cs_n}, 32'hF);
        addr = 24'hFFE800; #1;
        check("R7 below regwin", {28'h0, cs_n}, 32'h7);
        addr = 24'h200010; fc = 3'd5; rw = 1'b0; #1;
        check("R4 fc match", {28'h0, cs_n}, 32'hB);
        fc = 3'd1; #1;
        check("R4 fc mismatch", {28'h0, cs_n}, 32'h7);
        as_n = 1'b1; #1;
        check("R9 strobe high", {28'h0, cs_n}, 32'hF);
        @(negedge clk);

        // R10 R11 timing
        strobe(24'h108000, 3'd2, 1'b1, 1'b0, n);
        check("R10 two waits", n, 3);
        strobe(24'h108000, 3'd2, 1'b1, 1'b0, n);
        check("R10 restart", n, 3);
        strobe(24'h201000, 3'd5, 1'b0, 1'b0, n);
        check("R10 zero waits", n, 1);
        strobe(24'h500000, 3'd1, 1'b1, 1'b0, n);
        check("R11 external", n, 0);
        strobe(24'h000000, 3'd7, 1'b1, 1'b0, n);
        check("R11 iack", n, 0);

        // R12 locked
        rmw_wait_en = 1'b0;
        strobe(24'h000100, 3'd5, 1'b1, 1'b1, n);
        check("R12 locked read", n, 7);
        strobe(24'h000100, 3'd5, 1'b0, 1'b1, n);
        check("R12 locked write fast", n, 1);
        rmw_wait_en = 1'b1;
        strobe(24'h000100, 3'd5, 1'b0, 1'b1, n);
        check("R12 locked write waits", n, 7);
        rmw_wait_en = 1'b0;

        // R13 disable line 2
        wr(3'd4, 16'hA400);
        line2_on = 1'b0;
        as_n = 1'b0; addr = 24'h200010; fc = 3'd5; rw = 1'b0; #1;
        check("R13 disabled", {28'h0, cs_n}, {28'h0, model(addr, fc, rw)});
        as_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule